// File: doc/BRIEF.md
# Polar Code Two-Bit Final-Stage Decision Node

This node sits at the end of a successive-cancellation polar decoder, in place of the last stage of f and g processing elements. Each accepted beat carries two log-likelihood ratios in sign-magnitude form, `llr_c` and `llr_d`, from the stage before it. It also carries two frozen flags: `frz_odd` for the first bit of the pair (odd index) and `frz_even` for the second bit (even index). One clock edge later the node presents both hard decisions of the pair together.

No adder, f/g evaluation or four-way maximum search is built. The joint decision over the metrics {c+d, 0, d, c} is reduced to the two sign bits, a pair of magnitude comparisons and the frozen flags. The decoder around the node produces the LLRs and tracks partial sums.

A two-state controller follows the output register. `ST_IDLE` means no pair is presented. `ST_OUT` means the registered pair is valid. Any cycle with `in_valid` high moves the controller to `ST_OUT` (IDLE→OUT, or OUT→OUT). Any cycle with `in_valid` low returns it to `ST_IDLE` (OUT→IDLE, or IDLE→IDLE). Asynchronous reset forces `ST_IDLE`.

Top module: `polar_pair_node`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `bit_odd` and `bit_even` are 0.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R3: With both flags clear, the pair {bit_odd, bit_even} depends only on the sign bits (sign_c, sign_d). The mapping is (0,0)→00, (1,1)→01, (1,0)→10 and (0,1)→11, so bit_odd = sign_c XOR sign_d and bit_even = sign_d. Magnitudes have no effect.
- R4: With only `frz_odd` set, bit_odd is 0. bit_even is 1 exactly when c+d is negative. Two negative signs count as negative. For differing signs, the sum is negative only when the negative operand has the strictly larger magnitude.
- R5: With only `frz_odd` set, signs that differ and magnitudes that are equal give bit_even = 0.
- R6: With only `frz_even` set, bit_even is 0 and bit_odd = sign_c XOR sign_d.
- R7: With both flags set, both output bits are 0.
- R8: A cycle with `in_valid` low leaves `bit_odd` and `bit_even` unchanged.
- R9: In each LLR the most significant bit is the sign (1 = negative). The remaining LLR_W-1 bits are the unsigned magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs carry a pair to decide |
| llr_c | input | LLR_W | First LLR, sign-magnitude |
| llr_d | input | LLR_W | Second LLR, sign-magnitude |
| frz_odd | input | 1 | Odd bit of the pair is frozen |
| frz_even | input | 1 | Even bit of the pair is frozen |
| out_valid | output | 1 | Registered pair is valid |
| bit_odd | output | 1 | Decided odd bit |
| bit_even | output | 1 | Decided even bit |

## Verification
The bound checker checks the following on every cycle:
- the valid latency of one clock;
- holding of the decisions during idle cycles;
- the forced zeros for frozen bits;
- the sign-only rule when both bits are free;
- the even decision when the odd bit is frozen, against a signed sum that the checker computes itself.

Only the bench's scenarios can show two things: the zero-magnitude and equal-magnitude corners, and that the field layout of R9 is read as intended. The bench covers these by sweeping every pair of 5-bit codes under all four flag settings, with back-to-back beats followed by idle gaps.

// File: rtl/polar_pair_pkg.sv
package polar_pair_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_OUT  = 1'b1
    } pair_state_e;

    typedef struct packed {
        logic odd;
        logic even;
    } pair_bits_t;

endpackage

// File: rtl/pair_mag_cmp.sv
module pair_mag_cmp #(
    parameter int MAG_W = 4
) (
    input  logic [MAG_W-1:0] mag_c,
    input  logic [MAG_W-1:0] mag_d,
    output logic             c_gt,
    output logic             d_gt
);
    always_comb begin
        c_gt = (mag_c > mag_d);
        d_gt = (mag_d > mag_c);
    end
endmodule

// File: rtl/pair_decide.sv
module pair_decide
    import polar_pair_pkg::*;
(
    input  logic       sign_c,
    input  logic       sign_d,
    input  logic       c_gt,
    input  logic       d_gt,
    input  logic       frz_odd,
    input  logic       frz_even,
    output pair_bits_t pair
);
    logic sign_diff;
    logic sum_neg;

    always_comb begin
        sign_diff = sign_c ^ sign_d;
        // negative sum: both negative, or the negative side dominates strictly
        sum_neg   = (sign_c & sign_d)
                  | (sign_c & ~sign_d & c_gt)
                  | (~sign_c & sign_d & d_gt);
        unique case ({frz_odd, frz_even})
            2'b00: begin
                pair.odd  = sign_diff;
                pair.even = sign_d;
            end
            2'b10: begin
                pair.odd  = 1'b0;
                pair.even = sum_neg;
            end
            2'b01: begin
                pair.odd  = sign_diff;
                pair.even = 1'b0;
            end
            default: begin
                pair.odd  = 1'b0;
                pair.even = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/polar_pair_node.sv
module polar_pair_node
    import polar_pair_pkg::*;
#(
    parameter int LLR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [LLR_W-1:0] llr_c,
    input  logic [LLR_W-1:0] llr_d,
    input  logic             frz_odd,
    input  logic             frz_even,
    output logic             out_valid,
    output logic             bit_odd,
    output logic             bit_even
);
    localparam int MAG_W = LLR_W - 1;
    localparam int SGN   = LLR_W - 1;

    pair_state_e state_q, state_d;
    pair_bits_t  pair_now, pair_q;
    logic        c_gt, d_gt;

    pair_mag_cmp #(.MAG_W(MAG_W)) i_cmp (
        .mag_c (llr_c[MAG_W-1:0]),
        .mag_d (llr_d[MAG_W-1:0]),
        .c_gt  (c_gt),
        .d_gt  (d_gt)
    );

    pair_decide i_dec (
        .sign_c   (llr_c[SGN]),
        .sign_d   (llr_d[SGN]),
        .c_gt     (c_gt),
        .d_gt     (d_gt),
        .frz_odd  (frz_odd),
        .frz_even (frz_even),
        .pair     (pair_now)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_OUT : ST_IDLE;
            ST_OUT:  state_d = in_valid ? ST_OUT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pair_q <= '0;
        else if (in_valid) pair_q <= pair_now;
    end

    assign out_valid = (state_q == ST_OUT);
    assign bit_odd   = pair_q.odd;
    assign bit_even  = pair_q.even;
endmodule

// File: rtl/polar_pair_chk.sv
module polar_pair_chk #(
    parameter int LLR_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [LLR_W-1:0] llr_c,
    input logic [LLR_W-1:0] llr_d,
    input logic             frz_odd,
    input logic             frz_even,
    input logic             out_valid,
    input logic             bit_odd,
    input logic             bit_even
);
    logic                  sc, sd, neg_pair;
    logic signed [LLR_W:0]   val_c, val_d;
    logic signed [LLR_W+1:0] sum_cd;

    always_comb begin
        sc     = llr_c[LLR_W-1];
        sd     = llr_d[LLR_W-1];
        val_c  = sc ? -$signed({2'b00, llr_c[LLR_W-2:0]}) : $signed({2'b00, llr_c[LLR_W-2:0]});
        val_d  = sd ? -$signed({2'b00, llr_d[LLR_W-2:0]}) : $signed({2'b00, llr_d[LLR_W-2:0]});
        sum_cd = LLR_W'(0) + val_c + val_d;
        neg_pair = (sc & sd) | ((sc ^ sd) & (sum_cd < 0));
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !bit_odd && !bit_even));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    free_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !frz_odd && !frz_even) |=>
            (bit_odd == $past(sc ^ sd)) && (bit_even == $past(sd)));

    // R4
    odd_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && frz_odd && !frz_even) |=>
            (!bit_odd && (bit_even == $past(neg_pair))));

    // R6
    even_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !frz_odd && frz_even) |=>
            (!bit_even && (bit_odd == $past(sc ^ sd))));

    // R7
    both_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && frz_odd && frz_even) |=> (!bit_odd && !bit_even));

    // R8
    hold_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable({bit_odd, bit_even}));
endmodule

bind polar_pair_node polar_pair_chk #(.LLR_W(LLR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .llr_c     (llr_c),
    .llr_d     (llr_d),
    .frz_odd   (frz_odd),
    .frz_even  (frz_even),
    .out_valid (out_valid),
    .bit_odd   (bit_odd),
    .bit_even  (bit_even)
);

// File: tb/test_polar_pair_node.sv
`timescale 1ns/1ps
module test_polar_pair_node;
    localparam int W = 5;
    localparam int M = W - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] llr_c = '0;
    logic [W-1:0] llr_d = '0;
    logic         frz_odd = 1'b0;
    logic         frz_even = 1'b0;
    logic         out_valid, bit_odd, bit_even;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    polar_pair_node #(.LLR_W(W)) i_polar_pair_node (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .llr_c(llr_c), .llr_d(llr_d), .frz_odd(frz_odd), .frz_even(frz_even),
        .out_valid(out_valid), .bit_odd(bit_odd), .bit_even(bit_even)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected pair {odd, even} from the requirements
    function automatic logic [1:0] expect_pair(input int c, input int d, input bit fo, input bit fe);
        bit sc, sd;
        int vc, vd;
        sc = c[M]; sd = d[M];
        vc = sc ? -(c % (1 << M)) : (c % (1 << M));
        vd = sd ? -(d % (1 << M)) : (d % (1 << M));
        if (fo && fe) return 2'b00;
        if (fo) return {1'b0, (sc && sd) || ((sc != sd) && (vc + vd < 0))};
        if (fe) return {sc ^ sd, 1'b0};
        case ({sc, sd})
            2'b00:   return 2'b00;
            2'b11:   return 2'b01;
            2'b10:   return 2'b10;
            default: return 2'b11;
        endcase
    endfunction

    function automatic string req_of(input int c, input int d, input bit fo, input bit fe);
        if (fo && fe) return "R7";
        if (fe) return "R6";
        if (fo) begin
            if ((c[M] != d[M]) && ((c % (1 << M)) == (d % (1 << M)))) return "R5";
            return "R4";
        end
        return "R3";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [1:0] last;
        repeat (3) @(negedge clk);
        check(!out_valid && !bit_odd && !bit_even, "R1", {out_valid, bit_odd, bit_even}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid, "R2 idle", out_valid, 0);

        last = 2'b00;
        for (int f = 0; f < 4; f++) begin
            for (int c = 0; c < (1 << W); c++) begin
                for (int d = 0; d < (1 << W); d++) begin
                    in_valid = 1'b1;
                    llr_c = W'(c); llr_d = W'(d);
                    frz_odd = f[1]; frz_even = f[0];
                    @(negedge clk);
                    last = expect_pair(c, d, f[1], f[0]);
                    check(out_valid, "R2", out_valid, 1);
                    check({bit_odd, bit_even} == last, req_of(c, d, f[1], f[0]),
                          {bit_odd, bit_even}, last);
                end
            end
        end

        // idle cycles with changing inputs: bits must hold
        for (int k = 0; k < 3; k++) begin
            in_valid = 1'b0;
            llr_c = W'(k * 7 + 3); llr_d = W'(k * 11 + 17);
            frz_odd = k[0]; frz_even = 1'b0;
            @(negedge clk);
            check(!out_valid, "R2 drop", out_valid, 0);
            check({bit_odd, bit_even} == last, "R8", {bit_odd, bit_even}, last);
        end

        // field layout: +1 and -2 with odd frozen gives negative sum
        in_valid = 1'b1; frz_odd = 1'b1; frz_even = 1'b0;
        llr_c = 5'b0_0001; llr_d = 5'b1_0010;
        @(negedge clk);
        check(bit_even == 1'b1 && !bit_odd, "R9 neg", {bit_odd, bit_even}, 1);
        llr_c = 5'b0_0010; llr_d = 5'b1_0001;
        @(negedge clk);
        check(bit_even == 1'b0 && !bit_odd, "R9 pos", {bit_odd, bit_even}, 0);

        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!out_valid && !bit_odd && !bit_even, "R1 again", {out_valid, bit_odd, bit_even}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule